// File: doc/BRIEF.md
# Admin Command Queue Engine

This block is the device-side executor for a ring of administrative command slots that fill one memory page. Host software writes commands into consecutive slots, adds the number of new commands to its running submission count, and writes that count to a doorbell register. The engine then works through the slots one at a time, from its own executed count up to the doorbell value. For each command it fetches the opcode, writes a status word back into the same slot, and only then bumps its executed count. Software polls that count until it equals the doorbell value it wrote.

A page-frame register sets the location of the slot array. Writing a zero frame number to it acts as a full reset. The executed count and the doorbell copy return to zero, any command in flight is dropped without a write-back, and the engine stays idle until a nonzero frame is written again. All register traffic and all command words are big-endian on the wire. The opcode decode is a small stub: opcodes 1 to `NUM_OPS` complete successfully and every other value is reported as unsupported.

Top module: `aq_engine`

## Requirements
- R1: After `rst_ni` is asserted, `evt_cnt_o` reads zero, `busy_o` is low and neither `mem_re_o` nor `mem_we_o` is active.
- R2: The slot index is the executed count modulo 64 (4096-byte page, 64-byte slots), so command 64 reuses slot 0. The opcode read is at byte address `{frame, slot, 6'h00}`.
- R3: The status word goes to byte offset 4 of the same slot, exactly two cycles after that slot's opcode read. The executed count rises only after this write, never in the same cycle.
- R4: The status is 1 for opcodes 1 to 3 and 2 for any other opcode, including 0. Opcode and status words are big-endian on the memory bus.
- R5: The engine executes commands in slot order until the executed count equals the doorbell copy and then goes idle. `evt_cnt_o` shows the count big-endian and only steps by one, or clears to zero.
- R6: A doorbell value that is not ahead of the executed count under modulo-2^32 signed comparison is ignored and starts no work. This covers equal values, smaller values and values more than 2^31 ahead.
- R7: While the page frame is zero, doorbell writes are ignored and no memory access occurs.
- R8: A page-frame register write whose 20-bit frame field is zero clears the executed count, the doorbell copy and the frame, and aborts a command in flight with no status write.
- R9: The first command completes five cycles after the doorbell is captured. Back-to-back commands complete every five cycles.
- R10: Register write data is big-endian. `reg_sel_i` = 0 selects the page-frame register, whose low 20 bits hold the frame. `reg_sel_i` = 1 selects the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: page-frame register, 1: doorbell |
| reg_wdata_i | input | 32 | Register write data, big-endian |
| evt_cnt_o | output | 32 | Executed-command count, big-endian |
| busy_o | output | 1 | A command is in flight |
| mem_re_o | output | 1 | Opcode read strobe |
| mem_we_o | output | 1 | Status write strobe |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | 32 | Status word, big-endian |
| mem_rdata_i | input | 32 | Opcode word returned in the read cycle, big-endian |

## Verification
The assertions check several properties on every cycle. The count only ever steps by one or clears. Each status write lands in the slot read two cycles before, and each count step follows such a write. No read is issued unless the doorbell copy is ahead of the count, memory stays silent while the frame is zero, and a zero-frame write clears all state on the next cycle. The bench scenarios show the rest: the opcode-to-status mapping, slot reuse after 64 commands, the rejection of stale and far-ahead doorbell values, the five-cycle pacing, and an abort that leaves the slot being fetched untouched.

// File: rtl/aq_pkg.sv
package aq_pkg;
  localparam int unsigned REG_W = 32;
  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_WBACK, ST_RETIRE
  } aq_state_e;

  localparam word_t STS_DONE  = 32'h0000_0001;
  localparam word_t STS_UNSUP = 32'h0000_0002;

  function automatic word_t bswap(word_t w);
    word_t r;
    for (int b = 0; b < REG_W / 8; b++) r[8*b +: 8] = w[REG_W-8-8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/aq_regs.sv
module aq_regs
  import aq_pkg::*;
#(
  parameter int unsigned PFN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  word_t            wdata_i,
  input  word_t            cnt_i,
  output logic [PFN_W-1:0] pfn_o,
  output word_t            db_o,
  output logic             clr_o
);
  word_t            val;
  logic [PFN_W-1:0] pfn_new;
  logic             db_ok;

  assign val     = bswap(wdata_i);
  assign pfn_new = val[PFN_W-1:0];
  assign clr_o   = wr_i && !sel_i && (pfn_new == '0);
  // doorbell must be ahead of executed count (mod 2^32)
  assign db_ok   = wr_i && sel_i && (pfn_o != '0) &&
                   ($signed(word_t'(val - cnt_i)) > 32'sd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfn_o <= '0;
      db_o  <= '0;
    end else if (clr_o) begin
      pfn_o <= '0;
      db_o  <= '0;
    end else begin
      if (wr_i && !sel_i) pfn_o <= pfn_new;
      if (db_ok)          db_o  <= val;
    end
  end
endmodule

// File: rtl/aq_decode.sv
module aq_decode
  import aq_pkg::*;
#(
  parameter int unsigned NUM_OPS = 3
) (
  input  word_t op_i,
  output word_t sts_o
);
  assign sts_o = ((op_i != '0) && (op_i <= word_t'(NUM_OPS))) ? STS_DONE : STS_UNSUP;
endmodule

// File: rtl/aq_seq.sv
module aq_seq
  import aq_pkg::*;
#(
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned SLOT_W  = 6,
  parameter int unsigned OFS_W   = 6,
  parameter int unsigned STS_OFS = 4,
  localparam int unsigned ADDR_W = PFN_W + SLOT_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [PFN_W-1:0]  pfn_i,
  input  word_t             db_i,
  input  word_t             rdata_i,
  input  word_t             sts_i,
  output word_t             op_o,
  output word_t             cnt_o,
  output logic              busy_o,
  output logic              re_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output word_t             wdata_o
);
  aq_state_e state_q;
  word_t     sts_q;
  logic      pending;

  assign pending = $signed(word_t'(db_i - cnt_o)) > 32'sd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_o   <= '0;
      op_o    <= '0;
      sts_q   <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      cnt_o   <= '0;
      op_o    <= '0;
      sts_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (pending) state_q <= ST_FETCH;
        ST_FETCH:  begin op_o <= bswap(rdata_i); state_q <= ST_EXEC; end
        ST_EXEC:   begin sts_q <= sts_i; state_q <= ST_WBACK; end
        ST_WBACK:  state_q <= ST_RETIRE;
        ST_RETIRE: begin cnt_o <= cnt_o + word_t'(1); state_q <= ST_IDLE; end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign re_o    = (state_q == ST_FETCH);
  assign we_o    = (state_q == ST_WBACK);
  assign busy_o  = (state_q != ST_IDLE);
  assign addr_o  = {pfn_i, cnt_o[SLOT_W-1:0], we_o ? OFS_W'(STS_OFS) : OFS_W'(0)};
  assign wdata_o = bswap(sts_q);
endmodule

// File: rtl/aq_engine.sv
module aq_engine
  import aq_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned CMD_BYTES  = 64,
  parameter int unsigned PFN_W      = 20,
  parameter int unsigned NUM_OPS    = 3,
  parameter int unsigned STS_OFS    = 4,
  localparam int unsigned ADDR_W    = PFN_W + $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       evt_cnt_o,
  output logic              busy_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  localparam int unsigned SLOTS  = PAGE_BYTES / CMD_BYTES;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned OFS_W  = $clog2(CMD_BYTES);

  logic [PFN_W-1:0] pfn_q;
  word_t            db_q, evt_cnt, op, sts;
  logic             clr;

  aq_regs #(.PFN_W(PFN_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (evt_cnt),
    .pfn_o   (pfn_q),
    .db_o    (db_q),
    .clr_o   (clr)
  );

  aq_decode #(.NUM_OPS(NUM_OPS)) u_dec (
    .op_i  (op),
    .sts_o (sts)
  );

  aq_seq #(
    .PFN_W   (PFN_W),
    .SLOT_W  (SLOT_W),
    .OFS_W   (OFS_W),
    .STS_OFS (STS_OFS)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .pfn_i   (pfn_q),
    .db_i    (db_q),
    .rdata_i (mem_rdata_i),
    .sts_i   (sts),
    .op_o    (op),
    .cnt_o   (evt_cnt),
    .busy_o  (busy_o),
    .re_o    (mem_re_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  assign evt_cnt_o = bswap(evt_cnt);
endmodule

// File: rtl/aq_engine_chk.sv
module aq_engine_chk #(
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_re_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [31:0]       cnt_i,
  input logic [31:0]       db_i,
  input logic [PFN_W-1:0]  pfn_i,
  input logic              clr_i
);
  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 32'd1 || cnt_i == 32'd0));

  a_r3_retire_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i) && cnt_i != 32'd0) |-> $past(mem_we_i, 2));

  a_r3_wb_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> $past(mem_re_i, 2));

  a_r2_same_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (mem_addr_i[ADDR_W-PFN_W-1:OFS_W] == $past(mem_addr_i[ADDR_W-PFN_W-1:OFS_W], 2)));

  a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_i |-> ($signed(db_i - cnt_i) > 32'sd0));

  a_r7_silent_no_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfn_i == '0) |-> !(mem_re_i || mem_we_i));

  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_i == 32'd0 && db_i == 32'd0 && pfn_i == '0));
endmodule

bind aq_engine aq_engine_chk #(
  .PFN_W  (PFN_W),
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_re_i   (mem_re_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .cnt_i      (evt_cnt),
  .db_i       (db_q),
  .pfn_i      (pfn_q),
  .clr_i      (clr)
);

// File: tb/aq_engine_test.sv
module aq_engine_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] evt_cnt, mem_wdata, mem_rdata;
  logic        busy, mem_re, mem_we;
  logic [31:0] mem_addr;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int slot0_writes = 0;

  localparam logic [19:0] PG_A = 20'h12345;
  localparam logic [19:0] PG_B = 20'h00077;

  always #10 clk = ~clk;

  aq_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .evt_cnt_o(evt_cnt), .busy_o(busy),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] be(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [10:0] idx(logic [31:0] a);
    return {a[31:12] == PG_B, a[11:2]};
  endfunction

  // host memory: two pages
  logic [31:0] mem [0:2047];
  always_comb mem_rdata = mem[idx(mem_addr)];
  always @(negedge clk) if (rst_n && mem_we) begin
    mem[idx(mem_addr)] = mem_wdata;
    if (mem_addr == {PG_A, 12'h004}) slot0_writes++;
  end

  // behavioural reference model
  int          m_phase = 0;
  logic [31:0] m_cnt = '0, m_db = '0, m_op = '0, m_sts = '0;
  logic [19:0] m_pfn = '0;
  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] v;
    bit clr, dbw, pend;
    if (!rst_n) begin
      m_phase = 0; m_cnt = '0; m_db = '0; m_op = '0; m_sts = '0; m_pfn = '0;
    end else begin
      v    = be(reg_wdata);
      clr  = reg_wr && !reg_sel && v[19:0] == '0;
      pend = $signed(m_db - m_cnt) > 0;
      dbw  = reg_wr && reg_sel && m_pfn != '0 && $signed(v - m_cnt) > 0;
      if (clr) begin
        m_phase = 0; m_cnt = '0; m_db = '0; m_op = '0; m_sts = '0; m_pfn = '0;
      end else begin
        case (m_phase)
          0: if (pend) m_phase = 1;
          1: begin m_op = be(mem[idx({m_pfn, m_cnt[5:0], 6'd0})]); m_phase = 2; end
          2: begin m_sts = (m_op >= 1 && m_op <= 3) ? 32'd1 : 32'd2; m_phase = 3; end
          3: m_phase = 4;
          default: begin m_cnt = m_cnt + 1; m_phase = 0; end
        endcase
        if (reg_wr && !reg_sel) m_pfn = v[19:0];
        if (dbw) m_db = v;
      end
    end
  end

  task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin : cmp
    logic [31:0] ea;
    ea = {m_pfn, m_cnt[5:0], (m_phase == 3) ? 6'd4 : 6'd0};
    vectors++;
    if (mem_re !== (m_phase == 1)) fail("R2", "read strobe", 32'(mem_re), 32'(m_phase == 1));
    if (mem_we !== (m_phase == 3)) fail("R3", "write strobe", 32'(mem_we), 32'(m_phase == 3));
    if ((mem_re || mem_we) && mem_addr !== ea) fail("R2", "address", mem_addr, ea);
    if (mem_we && mem_wdata !== be(m_sts)) fail("R4", "status word", mem_wdata, be(m_sts));
    if (evt_cnt !== be(m_cnt)) fail("R5", "event count", evt_cnt, be(m_cnt));
    if (busy !== (m_phase != 0)) fail("R9", "busy", 32'(busy), 32'(m_phase != 0));
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) fail(req, what, act, exp);
  endtask

  task automatic reg_write(logic sel, logic [31:0] host_val);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = be(host_val);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wait_cnt(logic [31:0] n, int limit);
    for (int i = 0; i < limit && evt_cnt !== be(n); i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fail("R9", "watchdog expired", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int k;
    for (int i = 0; i < 64; i++) begin
      mem[{1'b0, 6'(i), 4'd0}] = be(32'(i % 5));
      mem[{1'b0, 6'(i), 4'd1}] = 32'hDEADBEEF;
      mem[{1'b1, 6'(i), 4'd0}] = be((i == 0) ? 32'd3 : 32'd7);
      mem[{1'b1, 6'(i), 4'd1}] = 32'hDEADBEEF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "count after reset", evt_cnt, 32'd0);
    check("R1", "busy after reset", 32'(busy), 32'd0);
    check("R1", "no access after reset", 32'(mem_re | mem_we), 32'd0);

    // R7: doorbell before any page frame
    reg_write(1'b1, 32'd3);
    repeat (8) @(negedge clk);
    check("R7", "count with no page", evt_cnt, 32'd0);
    check("R7", "idle with no page", 32'(busy), 32'd0);

    // R10: page frame register, big-endian
    reg_write(1'b0, {12'd0, PG_A});
    repeat (3) @(negedge clk);
    check("R7", "idle with page but no doorbell", 32'(busy), 32'd0);

    // R9: latency and pacing
    reg_write(1'b1, 32'd3);
    k = 1;
    while (evt_cnt !== be(32'd1) && k < 50) begin @(negedge clk); k++; end
    check("R9", "first completion cycles", 32'(k), 32'd6);
    k = 0;
    while (evt_cnt !== be(32'd2) && k < 50) begin @(negedge clk); k++; end
    check("R9", "completion interval", 32'(k), 32'd5);
    repeat (12) @(negedge clk);
    check("R5", "stops at doorbell", evt_cnt, be(32'd3));
    check("R5", "idle at doorbell", 32'(busy), 32'd0);
    check("R4", "opcode 0 unsupported", mem[{1'b0, 6'd0, 4'd1}], be(32'd2));
    check("R4", "opcode 1 done", mem[{1'b0, 6'd1, 4'd1}], be(32'd1));
    check("R3", "opcode 2 written", mem[{1'b0, 6'd2, 4'd1}], be(32'd1));
    check("R5", "next slot untouched", mem[{1'b0, 6'd3, 4'd1}], 32'hDEADBEEF);

    // R6: stale, equal and far-ahead doorbells
    reg_write(1'b1, 32'd2);
    reg_write(1'b1, 32'd3);
    reg_write(1'b1, 32'h8000_0003);
    repeat (10) @(negedge clk);
    check("R6", "count after stale doorbells", evt_cnt, be(32'd3));
    check("R6", "idle after stale doorbells", 32'(busy), 32'd0);

    // R2: slot wrap past 64
    reg_write(1'b1, 32'd70);
    wait_cnt(32'd70, 600);
    check("R5", "count after long batch", evt_cnt, be(32'd70));
    check("R2", "slot 0 reused", 32'(slot0_writes), 32'd2);
    check("R4", "opcode 3 done", mem[{1'b0, 6'd3, 4'd1}], be(32'd1));
    check("R4", "opcode 4 unsupported", mem[{1'b0, 6'd4, 4'd1}], be(32'd2));

    // R8: abort in flight
    mem[{1'b0, 6'd6, 4'd1}] = 32'hCAFEF00D;
    reg_write(1'b1, 32'd75);
    reg_write(1'b0, 32'd0);
    repeat (8) @(negedge clk);
    check("R8", "count cleared", evt_cnt, 32'd0);
    check("R8", "idle after clear", 32'(busy), 32'd0);
    check("R8", "aborted slot untouched", mem[{1'b0, 6'd6, 4'd1}], 32'hCAFEF00D);
    reg_write(1'b1, 32'd1);
    repeat (8) @(negedge clk);
    check("R7", "doorbell after clear ignored", evt_cnt, 32'd0);

    // restart on a new page
    reg_write(1'b0, {12'd0, PG_B});
    reg_write(1'b1, 32'd2);
    wait_cnt(32'd2, 40);
    repeat (3) @(negedge clk);
    check("R10", "count on new page", evt_cnt, be(32'd2));
    check("R4", "new page opcode 3", mem[{1'b1, 6'd0, 4'd1}], be(32'd1));
    check("R4", "new page opcode 7", mem[{1'b1, 6'd1, 4'd1}], be(32'd2));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule